// File: doc/BRIEF.md
# Packed 4-bit pixel fetch and serializer

This block turns a stream of display slots into a stream of 16-colour pixel codes. The timing generator describes each access slot with a byte index along the line and two active flags. From these the block forms the address of the display byte in video memory and reads one byte per slot. Each byte holds two 4-bit pixels, and the block emits them one after the other on the pixel clock. The pixel clock runs at twice the access rate. The left pixel comes from the upper nibble.

A frame is stored row-major with a stride of 160 bytes, which gives 320 pixels on each line. The first byte of the frame sits at 0000h, or at 4000h when the base select is set. A 240-line frame spans 9600h bytes. A 200-line frame fits below 8000h.

The address for each line comes from a line-start register. That register reloads during vertical blanking and steps by the stride at the end of each active line, so no multiplier is needed. A byte fetched in one slot is shown during the next slot. The colour code is forced to 0 for any slot outside the active region, and it is also forced to 0 while the active-low video enable is released.

Top module: `pix4_fetch_serializer`

## Requirements
- R1: While reset is held, and after reset until the first active slot has been captured, `pix` is 0.
- R2: During a slot with `h_act` and `v_act` both high, `mem_rd` is 1 and `mem_addr` = base + line*160 + `hcount`. The line number is 0 for the first active line after `v_act` was low, and it advances once the slot with `hcount` = 159 closes. `mem_rd` is 0 in every other slot.
- R3: The base is 0000h when `base_sel` = 0 and 4000h when `base_sel` = 1. The base is taken only while `v_act` is low. A change of `base_sel` while `v_act` is high has no effect on addresses until the next vertical blank.
- R4: `mem_rdata` is captured on the clock cycle in which `acc_end` is high. The following cycle shows bits [7:4] on `pix` and the cycle after that shows bits [3:0]. A byte of 24h therefore shows colour 2 and then colour 4.
- R5: A slot captured while `h_act` or `v_act` is low shows `pix` = 0 in both of its display cycles.
- R6: While `video_en_n` is 1, `pix` is 0 in that same cycle, whatever byte is being shown.
- R7: The last active address of a 240-line frame with `base_sel` = 1 is D5FFh (base + 95FFh). The last active address of a 200-line frame with `base_sel` = 0 is 7CFFh, below 8000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (twice the access rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_end | input | 1 | High on the last pixel-clock cycle of each access slot |
| hcount | input | 8 | Byte index of the current slot within the line |
| h_act | input | 1 | Current slot lies in the horizontal active region |
| v_act | input | 1 | Current line lies in the vertical active region |
| base_sel | input | 1 | Display base select: 0 gives 0000h, 1 gives 4000h |
| video_en_n | input | 1 | Active-low video enable; high blanks the output |
| mem_rdata | input | 8 | Byte read from video memory for the current slot |
| mem_addr | output | 16 | Video memory address of the current slot |
| mem_rd | output | 1 | Read request for the current slot |
| pix | output | 4 | Colour code of the current pixel |

## Verification
Full 240-line and 200-line frames are run with the memory returning an address-derived byte. These runs tell a wrong line stride or a wrong line advance apart from a correct one through the address check on every slot and through the final frame address. Video enable is toggled at random half-slots and base select is flipped at random in mid-frame. These stimuli separate blanking that tracks the enable in the same cycle from blanking that is latched, and they separate a base taken during vertical blank from one that follows the pin. A directed byte of 24h at address 0 shows whether the nibble order is swapped.

// File: rtl/pix4_pkg.sv
package pix4_pkg;
  localparam int unsigned PIX4_DATA_W    = 8;
  localparam int unsigned PIX4_PIX_W     = 4;
  localparam int unsigned PIX4_ADDR_W    = 16;
  localparam int unsigned PIX4_HCNT_W    = 8;
  localparam int unsigned PIX4_LINE_BYTES = 160;
  localparam int unsigned PIX4_BASE_ALT  = 32'h4000;
endpackage

// File: rtl/pix4_addr_gen.sv
module pix4_addr_gen #(
  parameter int unsigned ADDR_W     = pix4_pkg::PIX4_ADDR_W,
  parameter int unsigned HCNT_W     = pix4_pkg::PIX4_HCNT_W,
  parameter int unsigned LINE_BYTES = pix4_pkg::PIX4_LINE_BYTES,
  parameter int unsigned BASE_ALT   = pix4_pkg::PIX4_BASE_ALT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_end,
  input  logic [HCNT_W-1:0] hcount,
  input  logic              h_act,
  input  logic              v_act,
  input  logic              base_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              rd,
  output logic [ADDR_W-1:0] line_base,
  output logic              line_adv
);
  localparam logic [HCNT_W-1:0] LAST_IDX = HCNT_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(LINE_BYTES);

  function automatic logic [ADDR_W-1:0] base_of(input logic sel);
    return sel ? ADDR_W'(BASE_ALT) : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] lb,
                                                   input logic [HCNT_W-1:0] idx);
    return lb + ADDR_W'(idx);
  endfunction

  logic [ADDR_W-1:0] line_base_q;
  logic              slot_live;

  assign slot_live = h_act && v_act;
  assign line_adv  = slot_live && acc_end && (hcount == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base_q <= '0;
    end else if (!v_act) begin
      line_base_q <= base_of(base_sel);
    end else if (line_adv) begin
      line_base_q <= line_base_q + STRIDE;
    end
  end

  assign line_base = line_base_q;
  assign addr      = slot_addr(line_base_q, hcount);
  assign rd        = slot_live;
endmodule

// File: rtl/pix4_byte_latch.sv
module pix4_byte_latch #(
  parameter int unsigned DATA_W  = pix4_pkg::PIX4_DATA_W,
  parameter int unsigned PIX_W   = pix4_pkg::PIX4_PIX_W,
  parameter int unsigned PPB     = DATA_W / PIX_W,
  parameter int unsigned SLICE_W = (PPB > 1) ? $clog2(PPB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               live,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  byte_q,
  output logic               vis_q,
  output logic [SLICE_W-1:0] slice_q
);
  localparam logic [SLICE_W-1:0] LAST_SLICE = SLICE_W'(PPB - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      vis_q   <= 1'b0;
      slice_q <= LAST_SLICE;
    end else if (capture) begin
      byte_q  <= rdata;
      vis_q   <= live;
      slice_q <= '0;
    end else if (slice_q != LAST_SLICE) begin
      slice_q <= slice_q + SLICE_W'(1);
    end
  end
endmodule

// File: rtl/pix4_out_stage.sv
module pix4_out_stage #(
  parameter int unsigned DATA_W  = pix4_pkg::PIX4_DATA_W,
  parameter int unsigned PIX_W   = pix4_pkg::PIX4_PIX_W,
  parameter int unsigned PPB     = DATA_W / PIX_W,
  parameter int unsigned SLICE_W = (PPB > 1) ? $clog2(PPB) : 1
) (
  input  logic [DATA_W-1:0]  byte_q,
  input  logic               vis_q,
  input  logic [SLICE_W-1:0] slice_q,
  input  logic               video_en_n,
  output logic [PIX_W-1:0]   pix
);
  // Slice 0 is the leftmost pixel, taken from the most significant bits.
  function automatic logic [PIX_W-1:0] pick(input logic [DATA_W-1:0] b,
                                            input logic [SLICE_W-1:0] idx);
    return b[(PPB - 1 - int'(idx)) * PIX_W +: PIX_W];
  endfunction

  logic show;
  assign show = vis_q && !video_en_n;
  assign pix  = show ? pick(byte_q, slice_q) : '0;
endmodule

// File: rtl/pix4_fetch_serializer.sv
module pix4_fetch_serializer #(
  parameter int unsigned DATA_W     = pix4_pkg::PIX4_DATA_W,
  parameter int unsigned PIX_W      = pix4_pkg::PIX4_PIX_W,
  parameter int unsigned ADDR_W     = pix4_pkg::PIX4_ADDR_W,
  parameter int unsigned HCNT_W     = pix4_pkg::PIX4_HCNT_W,
  parameter int unsigned LINE_BYTES = pix4_pkg::PIX4_LINE_BYTES,
  parameter int unsigned BASE_ALT   = pix4_pkg::PIX4_BASE_ALT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_end,
  input  logic [HCNT_W-1:0] hcount,
  input  logic              h_act,
  input  logic              v_act,
  input  logic              base_sel,
  input  logic              video_en_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [PIX_W-1:0]  pix
);
  localparam int unsigned PPB     = DATA_W / PIX_W;
  localparam int unsigned SLICE_W = (PPB > 1) ? $clog2(PPB) : 1;

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0]  line_base_w;
  logic               line_adv_w;
  logic               capture_w;
  logic               live_w;
  logic [DATA_W-1:0]  byte_w;
  logic               vis_w;
  logic [SLICE_W-1:0] slice_w;

  assign capture_w = acc_end;
  assign live_w    = h_act && v_act;

  pix4_addr_gen #(
    .ADDR_W(ADDR_W), .HCNT_W(HCNT_W), .LINE_BYTES(LINE_BYTES), .BASE_ALT(BASE_ALT)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .acc_end(acc_end), .hcount(hcount),
    .h_act(h_act), .v_act(v_act), .base_sel(base_sel),
    .addr(mem_addr), .rd(mem_rd), .line_base(line_base_w), .line_adv(line_adv_w)
  );

  pix4_byte_latch #(
    .DATA_W(DATA_W), .PIX_W(PIX_W), .PPB(PPB), .SLICE_W(SLICE_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture_w), .live(live_w),
    .rdata(mem_rdata), .byte_q(byte_w), .vis_q(vis_w), .slice_q(slice_w)
  );

  pix4_out_stage #(
    .DATA_W(DATA_W), .PIX_W(PIX_W), .PPB(PPB), .SLICE_W(SLICE_W)
  ) u_out (
    .byte_q(byte_w), .vis_q(vis_w), .slice_q(slice_w),
    .video_en_n(video_en_n), .pix(pix)
  );
endmodule

// File: rtl/pix4_fetch_checker.sv
module pix4_fetch_checker #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PIX_W      = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned HCNT_W     = 8,
  parameter int unsigned LINE_BYTES = 160,
  parameter int unsigned BASE_ALT   = 32'h4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_end,
  input logic [HCNT_W-1:0] hcount,
  input logic              h_act,
  input logic              v_act,
  input logic              base_sel,
  input logic              video_en_n,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PIX_W-1:0]  pix,
  input logic [ADDR_W-1:0] line_base,
  input logic              line_adv,
  input logic              capture
);
  localparam logic [HCNT_W-1:0] LAST_IDX = HCNT_W'(LINE_BYTES - 1);

  // R2: consecutive live slots on one line address consecutive bytes
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_act && h_act && $past(v_act) && $past(h_act) && $past(acc_end) &&
     $past(hcount) != LAST_IDX && hcount == $past(hcount) + HCNT_W'(1))
    |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R2: a line-end event moves the line start by one stride
  p_line_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && v_act) |=> line_base == $past(line_base) + ADDR_W'(LINE_BYTES));

  // R3: vertical blank loads the selected base
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !v_act |=> line_base == ($past(base_sel) ? ADDR_W'(BASE_ALT) : '0));

  // R4: the cycle after a live capture shows the upper nibble
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && h_act && v_act) |=>
      (video_en_n || pix == $past(mem_rdata[DATA_W-1 -: PIX_W])));

  // R5: a slot captured outside the active region stays black
  p_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !(h_act && v_act)) |=> pix == '0);

  // R6: released enable blanks the output
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    video_en_n |-> pix == '0);
endmodule

bind pix4_fetch_serializer pix4_fetch_checker #(
  .DATA_W(DATA_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W), .HCNT_W(HCNT_W),
  .LINE_BYTES(LINE_BYTES), .BASE_ALT(BASE_ALT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_end(acc_end), .hcount(hcount),
  .h_act(h_act), .v_act(v_act), .base_sel(base_sel), .video_en_n(video_en_n),
  .mem_rdata(mem_rdata), .mem_addr(mem_addr), .pix(pix),
  .line_base(line_base_w), .line_adv(line_adv_w), .capture(capture_w)
);

// File: tb/pix4_fetch_serializer_bench.sv
`timescale 1ns/1ps
module pix4_fetch_serializer_bench;
  localparam int WD_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_end = 1'b0;
  logic [7:0]  hcount = '0;
  logic        h_act = 1'b0;
  logic        v_act = 1'b0;
  logic        base_sel = 1'b0;
  logic        video_en_n = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [3:0]  pix;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model state
  bit         prev_vis = 1'b0;
  logic [7:0] prev_byte = '0;
  int         line_no = 0;
  bit         exp_bsel = 1'b0;
  logic [15:0] last_addr = '0;
  logic [3:0] obs_a, obs_b;

  always #10 clk = ~clk;

  // Memory model: byte derived from address, 24h at address 0.
  function automatic logic [7:0] mem_model(input logic [15:0] a);
    logic [7:0] v;
    v = (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    return (a == 16'h0000) ? 8'h24 : v;
  endfunction

  function automatic logic [15:0] exp_addr(input bit bs, input int ln, input int h);
    int base;
    base = bs ? 16384 : 0;
    return 16'(base + ln * 160 + h);
  endfunction

  function automatic logic [3:0] exp_pix(input bit vis, input logic [7:0] b,
                                         input bit ven_n, input bit second);
    if (!vis || ven_n) return 4'h0;
    return second ? b[3:0] : b[7:4];
  endfunction

  assign mem_rdata = mem_model(mem_addr);

  pix4_fetch_serializer u_pix4_fetch_serializer (
    .clk(clk), .rst_n(rst_n), .acc_end(acc_end), .hcount(hcount),
    .h_act(h_act), .v_act(v_act), .base_sel(base_sel), .video_en_n(video_en_n),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .pix(pix)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string pix_tag(input bit vis, input bit ven_n);
    if (ven_n) return "R6 blank";
    if (!vis) return "R5 inactive";
    return "R4 nibble";
  endfunction

  // One access slot: two pixel-clock cycles, acc_end on the second.
  task automatic do_slot(input int h, input bit ha, input bit va,
                         input bit ven_a, input bit ven_b);
    bit live;
    logic [15:0] ea;
    live = ha && va;
    @(negedge clk);
    hcount = 8'(h); h_act = ha; v_act = va; acc_end = 1'b0; video_en_n = ven_a;
    #2;
    check("R2 rd", 32'(mem_rd), 32'(live));
    ea = exp_addr(exp_bsel, line_no, h);
    if (live) begin
      check(exp_bsel ? "R3 addr" : "R2 addr", 32'(mem_addr), 32'(ea));
      last_addr = ea;
    end
    obs_a = pix;
    check(pix_tag(prev_vis, ven_a), 32'(pix), 32'(exp_pix(prev_vis, prev_byte, ven_a, 1'b0)));
    @(negedge clk);
    acc_end = 1'b1; video_en_n = ven_b;
    #2;
    obs_b = pix;
    check(pix_tag(prev_vis, ven_b), 32'(pix), 32'(exp_pix(prev_vis, prev_byte, ven_b, 1'b1)));
    prev_vis  = live;
    prev_byte = mem_model(ea);
    if (!va) begin
      line_no  = 0;
      exp_bsel = base_sel;
    end else if (live && h == 159) begin
      line_no++;
    end
  endtask

  task automatic run_frame(input int nlines, input bit bsel, input bit rnd_ven,
                           input bit toggle_bsel);
    base_sel = bsel;
    for (int i = 0; i < 6; i++) do_slot(200, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int h = 0; h < 164; h++) begin
        bit va_n, vb_n;
        va_n = rnd_ven && ($urandom_range(0, 15) == 0);
        vb_n = rnd_ven && ($urandom_range(0, 15) == 0);
        if (toggle_bsel && $urandom_range(0, 31) == 0) base_sel = ~base_sel;
        do_slot(h, h < 160, 1'b1, va_n, vb_n);
      end
    end
    do_slot(200, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset pix", 32'(pix), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 after reset pix", 32'(pix), 32'h0);

    // R4 directed: 24h at address 0, base 0
    base_sel = 1'b0;
    for (int i = 0; i < 4; i++) do_slot(200, 1'b0, 1'b0, 1'b0, 1'b0);
    do_slot(0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_slot(1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R4 left pixel of 24h", 32'(obs_a), 32'h2);
    check("R4 right pixel of 24h", 32'(obs_b), 32'h4);
    // R5: blank slot after a live one shows black
    do_slot(2, 1'b0, 1'b1, 1'b0, 1'b0);
    do_slot(3, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 inactive slot left", 32'(obs_a), 32'h0);
    check("R5 inactive slot right", 32'(obs_b), 32'h0);

    // R3: short frames with mid-frame base flips and random enable
    run_frame(4, 1'b1, 1'b1, 1'b1);
    run_frame(3, 1'b0, 1'b1, 1'b1);

    // R7: full frames
    run_frame(240, 1'b1, 1'b1, 1'b0);
    check("R7 last address 240 lines", 32'(last_addr), 32'hD5FF);
    run_frame(200, 1'b0, 1'b1, 1'b0);
    check("R7 last address 200 lines", 32'(last_addr), 32'h7CFF);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule